// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block watches the bus that a processor core drives and decides when the core should stop for debugging. It has two comparator units. Each unit holds a value and a mask for the address, a value and a mask for the data, and a control value with its mask. A mask bit of one removes that bit from the comparison. A unit matches an access only when it is enabled and every bit that is not masked equals its programmed value. A match on an opcode fetch acts as a breakpoint. A match on a data access acts as a watchpoint.

Unit 1 can be made to depend on unit 0 in two ways. In chain mode it fires only after unit 0 has matched on an earlier access. In range mode it looks at unit 0's match on the same access. Breakpoints tag the fetched instruction, and the halt happens only if that instruction reaches execute. Watchpoints, debug requests and the force control all take effect at the next instruction boundary. A parallel register port on a 5-bit address gives access to every unit register, to the debug control and status registers, and to a pair of mailbox registers that pass words between the host and the core.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, every register reads 0, both units are disabled, the chain latch is clear, and `dbg_ack`, `rng`, `intr_block`, `comm_rx_full`, `comm_tx_full` and `core_rdata` are 0.
- R2: A unit matches only when each address bit and each data bit has its mask bit set or equals the programmed value. `rng[i]` is high in the cycle after an access that unit i matched.
- R3: Control value layout: bit 0 write, bits 2:1 size, bit 3 privileged, bit 4 opcode fetch, bit 5 the unit's `ext_in` bit, bit 6 chain, bit 7 range, bit 8 enable. The control mask covers bits 7:0. A unit with bit 8 clear never matches.
- R4: The range bit of unit 1 is compared with unit 0's match on the same access. Unit 0 has no range or chain source, so for unit 0 these bits compare against 0.
- R5: The chain bit of unit 1 is compared with a latch that unit 0's matches set on earlier accesses. A write to any unit 0 register clears the latch. Status bit 3 shows the latch.
- R6: A match on a fetch tags that instruction. `dbg_ack` rises only in the cycle after the second later fetch, which is when the tagged instruction enters execute. `flush` discards pending tags. Status bit 4 is set when the entry came from a breakpoint.
- R7: A match on a data access sets a pending flag (status bit 2). Debug state is entered at the next `instr_done`, and entry clears the flag.
- R8: Debug state is entered at `instr_done` while the level input `dbg_req` or the force bit (debug control bit 0) is high. `dbg_ack` then stays high until `dbg_resume`.
- R9: Register map: debug control at 00000 (6 bits), status at 00001, mailbox flags at 00100, mailbox data at 00101. Unit 0 is at 01000–01101 and unit 1 is at 10000–10101, in the order address value, address mask, data value, data mask, control value (9 bits), control mask (8 bits). Unmapped addresses read 0.
- R10: A host write to 00101 loads the host-to-core word and sets `comm_rx_full` (mailbox flags bit 0). A core read with `core_rd` clears it. A host write while the flag is set is ignored.
- R11: A `core_wr` loads the core-to-host word and sets `comm_tx_full` (mailbox flags bit 1). A host read of 00101 returns that word and clears the flag. A core write while the flag is set is ignored.
- R12: Status bits are 0 `dbg_ack`, 1 `dbg_req`, 2 watchpoint pending, 3 chain latch, 4 breakpoint cause. `intr_block` follows debug control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Core access this cycle |
| bus_fetch | input | 1 | Access is an opcode fetch |
| bus_write | input | 1 | Access is a write |
| bus_size | input | 2 | Access width code |
| bus_priv | input | 1 | Privileged access |
| bus_addr | input | 32 | Access address |
| bus_data | input | 32 | Access data |
| ext_in | input | 2 | Per-unit external qualifier |
| flush | input | 1 | Pipeline flush, drops breakpoint tags |
| instr_done | input | 1 | An instruction completes |
| dbg_req | input | 1 | Level debug request |
| dbg_resume | input | 1 | Leave debug state |
| core_wr | input | 1 | Core writes the mailbox |
| core_wdata | input | 32 | Core mailbox write data |
| core_rd | input | 1 | Core takes the host word |
| core_rdata | output | 32 | Host-to-core word |
| rng | output | 2 | Registered per-unit match |
| dbg_ack | output | 1 | High in debug state |
| intr_block | output | 1 | Interrupt disable control |
| comm_rx_full | output | 1 | Host-to-core word waiting |
| comm_tx_full | output | 1 | Core-to-host word waiting |

## Verification
The checker verifies on every cycle the following: `dbg_ack` rises only after an instruction boundary or a tagged instruction entering execute, and it holds until resume. A unit match never appears while that unit is disabled. The chain latch rises only together with unit 0's match. The mailbox flags change only on their own side's access. Whether a match is correct for a given value, mask and access pattern is left to the bench, which sweeps masks and addresses. The bench also runs the following scenarios: the range window, the chain order and its clearing, the two-fetch breakpoint delay with and without flush, and the register layout.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  localparam int RAW    = 5;
  localparam int CTRL_W = 9;
  localparam int CMSK_W = CTRL_W - 1;
  localparam int STAT_W = 5;
  localparam int DCTL_W = 6;

  localparam logic [RAW-1:0] A_DCTL  = 5'b00000;
  localparam logic [RAW-1:0] A_DSTAT = 5'b00001;
  localparam logic [RAW-1:0] A_CCTL  = 5'b00100;
  localparam logic [RAW-1:0] A_CDATA = 5'b00101;
  localparam logic [1:0]     PG_U0   = 2'b01;
  localparam logic [1:0]     PG_U1   = 2'b10;

  localparam logic [2:0] SEL_AV = 3'd0;
  localparam logic [2:0] SEL_AM = 3'd1;
  localparam logic [2:0] SEL_DV = 3'd2;
  localparam logic [2:0] SEL_DM = 3'd3;
  localparam logic [2:0] SEL_CV = 3'd4;
  localparam logic [2:0] SEL_CM = 3'd5;
  localparam logic [2:0] SEL_LIMIT = 3'd6;

  function automatic logic ctrl_eq(input logic [CMSK_W-1:0] v,
                                   input logic [CMSK_W-1:0] m,
                                   input logic [CMSK_W-1:0] o);
    return ((v ^ o) & ~m) == '0;
  endfunction
endpackage

// File: rtl/dbg_cmp_unit.sv
module dbg_cmp_unit
  import dbg_watch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [DW-1:0]     wdata,
  input  logic              obs_valid,
  input  logic [DW-1:0]     obs_addr,
  input  logic [DW-1:0]     obs_data,
  input  logic [CMSK_W-1:0] obs_ctrl,
  output logic              hit,
  output logic              armed,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0]     av, am, dv, dm;
  logic [CTRL_W-1:0] cv;
  logic [CMSK_W-1:0] cm;

  function automatic logic fld_eq(input logic [DW-1:0] v,
                                  input logic [DW-1:0] m,
                                  input logic [DW-1:0] o);
    return ((v ^ o) & ~m) == '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      av <= '0; am <= '0; dv <= '0; dm <= '0; cv <= '0; cm <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_AV:  av <= wdata;
        SEL_AM:  am <= wdata;
        SEL_DV:  dv <= wdata;
        SEL_DM:  dm <= wdata;
        SEL_CV:  cv <= wdata[CTRL_W-1:0];
        SEL_CM:  cm <= wdata[CMSK_W-1:0];
        default: ;
      endcase
    end
  end

  logic addr_ok, data_ok, ctrl_ok;
  assign addr_ok = fld_eq(av, am, obs_addr);
  assign data_ok = fld_eq(dv, dm, obs_data);
  assign ctrl_ok = ctrl_eq(cv[CMSK_W-1:0], cm, obs_ctrl);
  assign armed   = cv[CTRL_W-1];
  assign hit     = obs_valid & armed & addr_ok & data_ok & ctrl_ok;

  always_comb begin
    case (sel)
      SEL_AV:  rd_data = av;
      SEL_AM:  rd_data = am;
      SEL_DV:  rd_data = dv;
      SEL_DM:  rd_data = dm;
      SEL_CV:  rd_data = DW'(cv);
      SEL_CM:  rd_data = DW'(cm);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dbg_comms.sv
module dbg_comms #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  input  logic          core_wr,
  input  logic          core_rd,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] h2c_data,
  output logic [DW-1:0] c2h_data,
  output logic          h2c_full,
  output logic          c2h_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2c_data <= '0;
      h2c_full <= 1'b0;
    end else begin
      if (core_rd) h2c_full <= 1'b0;
      if (host_wr && !h2c_full) begin
        h2c_data <= host_wdata;
        h2c_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2h_data <= '0;
      c2h_full <= 1'b0;
    end else begin
      if (host_rd) c2h_full <= 1'b0;
      if (core_wr && !c2h_full) begin
        c2h_data <= core_wdata;
        c2h_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_halt_seq.sv
module dbg_halt_seq #(
  parameter int PIPE_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_cycle,
  input  logic bp_hit,
  input  logic wp_hit,
  input  logic flush,
  input  logic instr_done,
  input  logic dbg_req,
  input  logic force_dbg,
  input  logic resume,
  input  logic chain_clr,
  input  logic chain_set,
  output logic ack,
  output logic wp_pend,
  output logic chain_q,
  output logic cause_bp,
  output logic bp_exec,
  output logic enter
);
  logic [PIPE_DEPTH-1:0] tags;

  assign bp_exec = fetch_cycle & tags[PIPE_DEPTH-1] & ~flush & ~ack;
  assign enter   = ~ack & (bp_exec | (instr_done & (dbg_req | force_dbg | wp_pend)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tags <= '0;
    else if (flush || enter) tags <= '0;
    else if (fetch_cycle)    tags <= (tags << 1) | PIPE_DEPTH'(bp_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      wp_pend  <= 1'b0;
      cause_bp <= 1'b0;
    end else begin
      if (enter) begin
        ack      <= 1'b1;
        cause_bp <= bp_exec;
      end else if (resume) begin
        ack      <= 1'b0;
      end
      if (enter)              wp_pend <= 1'b0;
      else if (wp_hit && !ack) wp_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chain_q <= 1'b0;
    else if (chain_clr) chain_q <= 1'b0;
    else if (chain_set) chain_q <= 1'b1;
  end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int DW         = 32,
  parameter int PIPE_DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_en,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           bus_valid,
  input  logic           bus_fetch,
  input  logic           bus_write,
  input  logic [1:0]     bus_size,
  input  logic           bus_priv,
  input  logic [DW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_data,
  input  logic [1:0]     ext_in,
  input  logic           flush,
  input  logic           instr_done,
  input  logic           dbg_req,
  input  logic           dbg_resume,
  input  logic           core_wr,
  input  logic [DW-1:0]  core_wdata,
  input  logic           core_rd,
  output logic [DW-1:0]  core_rdata,
  output logic [1:0]     rng,
  output logic           dbg_ack,
  output logic           intr_block,
  output logic           comm_rx_full,
  output logic           comm_tx_full
);
  localparam int NUNITS = 2;

  logic wr_cyc, rd_cyc, sel_ok;
  assign wr_cyc = reg_en & reg_wr;
  assign rd_cyc = reg_en & ~reg_wr;
  assign sel_ok = reg_addr[2:0] < SEL_LIMIT;

  logic u0_wr, u1_wr;
  assign u0_wr = wr_cyc & (reg_addr[4:3] == PG_U0) & sel_ok;
  assign u1_wr = wr_cyc & (reg_addr[4:3] == PG_U1) & sel_ok;

  logic [DCTL_W-1:0] dctl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               dctl <= '0;
    else if (wr_cyc && reg_addr == A_DCTL)    dctl <= reg_wdata[DCTL_W-1:0];
  end
  assign intr_block = dctl[1];

  // named internal events, used by the checker
  logic u0_hit, u1_hit, u0_armed, u1_armed;
  logic chain_q, wp_pend, cause_bp, bp_exec, dbg_enter;
  logic fetch_cycle, bp_hit, wp_hit;
  logic [DW-1:0] u0_rd, u1_rd;

  logic [CMSK_W-1:0] u0_ctrl, u1_ctrl;
  assign u0_ctrl = {1'b0,   1'b0,    ext_in[0], bus_fetch, bus_priv, bus_size, bus_write};
  assign u1_ctrl = {u0_hit, chain_q, ext_in[1], bus_fetch, bus_priv, bus_size, bus_write};

  dbg_cmp_unit #(.DW(DW)) u_cmp0 (
    .clk(clk), .rst_n(rst_n), .wr_en(u0_wr), .sel(reg_addr[2:0]), .wdata(reg_wdata),
    .obs_valid(bus_valid), .obs_addr(bus_addr), .obs_data(bus_data), .obs_ctrl(u0_ctrl),
    .hit(u0_hit), .armed(u0_armed), .rd_data(u0_rd)
  );

  dbg_cmp_unit #(.DW(DW)) u_cmp1 (
    .clk(clk), .rst_n(rst_n), .wr_en(u1_wr), .sel(reg_addr[2:0]), .wdata(reg_wdata),
    .obs_valid(bus_valid), .obs_addr(bus_addr), .obs_data(bus_data), .obs_ctrl(u1_ctrl),
    .hit(u1_hit), .armed(u1_armed), .rd_data(u1_rd)
  );

  logic [NUNITS-1:0] hits;
  assign hits = {u1_hit, u0_hit};

  for (genvar gi = 0; gi < NUNITS; gi++) begin : g_rng
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rng[gi] <= 1'b0;
      else        rng[gi] <= hits[gi];
    end
  end

  assign fetch_cycle = bus_valid & bus_fetch;
  assign bp_hit      = fetch_cycle & (|hits);
  assign wp_hit      = bus_valid & ~bus_fetch & (|hits);

  dbg_halt_seq #(.PIPE_DEPTH(PIPE_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .fetch_cycle(fetch_cycle), .bp_hit(bp_hit), .wp_hit(wp_hit),
    .flush(flush), .instr_done(instr_done), .dbg_req(dbg_req), .force_dbg(dctl[0]),
    .resume(dbg_resume), .chain_clr(u0_wr), .chain_set(u0_hit),
    .ack(dbg_ack), .wp_pend(wp_pend), .chain_q(chain_q), .cause_bp(cause_bp),
    .bp_exec(bp_exec), .enter(dbg_enter)
  );

  logic [DW-1:0] c2h_data;
  dbg_comms #(.DW(DW)) u_comms (
    .clk(clk), .rst_n(rst_n),
    .host_wr(wr_cyc && reg_addr == A_CDATA), .host_rd(rd_cyc && reg_addr == A_CDATA),
    .host_wdata(reg_wdata), .core_wr(core_wr), .core_rd(core_rd), .core_wdata(core_wdata),
    .h2c_data(core_rdata), .c2h_data(c2h_data), .h2c_full(comm_rx_full), .c2h_full(comm_tx_full)
  );

  logic [STAT_W-1:0] stat;
  assign stat = {cause_bp, chain_q, wp_pend, dbg_req, dbg_ack};

  always_comb begin
    if (reg_addr == A_DCTL)              reg_rdata = DW'(dctl);
    else if (reg_addr == A_DSTAT)        reg_rdata = DW'(stat);
    else if (reg_addr == A_CCTL)         reg_rdata = DW'({comm_tx_full, comm_rx_full});
    else if (reg_addr == A_CDATA)        reg_rdata = c2h_data;
    else if (reg_addr[4:3] == PG_U0)     reg_rdata = u0_rd;
    else if (reg_addr[4:3] == PG_U1)     reg_rdata = u1_rd;
    else                                 reg_rdata = '0;
  end
endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk
  import dbg_watch_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           reg_en,
  input logic           reg_wr,
  input logic [RAW-1:0] reg_addr,
  input logic           dbg_ack,
  input logic           dbg_resume,
  input logic           instr_done,
  input logic           bp_exec,
  input logic [1:0]     rng,
  input logic           u0_armed,
  input logic           u1_armed,
  input logic           chain_q,
  input logic           wp_pend,
  input logic           comm_rx_full,
  input logic           comm_tx_full
);
  assert_ack_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_ack) |-> ($past(instr_done) || $past(bp_exec)));

  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ack && !dbg_resume) |=> dbg_ack);

  assert_rng0_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rng[0] |-> $past(u0_armed));

  assert_rng1_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rng[1] |-> $past(u1_armed));

  assert_chain_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_q) |-> rng[0]);

  assert_wp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wp_pend) |-> dbg_ack);

  assert_rx_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comm_rx_full) |-> $past(reg_en && reg_wr && reg_addr == A_CDATA));

  assert_tx_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(comm_tx_full) |-> $past(reg_en && !reg_wr && reg_addr == A_CDATA));
endmodule

bind dbg_watch_unit dbg_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .dbg_ack(dbg_ack), .dbg_resume(dbg_resume), .instr_done(instr_done), .bp_exec(bp_exec),
  .rng(rng), .u0_armed(u0_armed), .u1_armed(u1_armed), .chain_q(chain_q),
  .wp_pend(wp_pend), .comm_rx_full(comm_rx_full), .comm_tx_full(comm_tx_full)
);

// File: tb/dbg_watch_unit_bench.sv
module dbg_watch_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 0, reg_wr = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic bus_valid = 0, bus_fetch = 0, bus_write = 0, bus_priv = 0;
  logic [1:0] bus_size = '0, ext_in = '0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic flush = 0, instr_done = 0, dbg_req = 0, dbg_resume = 0;
  logic core_wr = 0, core_rd = 0;
  logic [31:0] core_wdata = '0, core_rdata;
  logic [1:0] rng;
  logic dbg_ack, intr_block, comm_rx_full, comm_tx_full;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rv;
  localparam logic [8:0] EN = 9'h100;

  always #2 clk = ~clk;

  dbg_watch_unit u_dbg_watch_unit (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
    .bus_write(bus_write), .bus_size(bus_size), .bus_priv(bus_priv), .bus_addr(bus_addr),
    .bus_data(bus_data), .ext_in(ext_in), .flush(flush), .instr_done(instr_done),
    .dbg_req(dbg_req), .dbg_resume(dbg_resume), .core_wr(core_wr), .core_wdata(core_wdata),
    .core_rd(core_rd), .core_rdata(core_rdata), .rng(rng), .dbg_ack(dbg_ack),
    .intr_block(intr_block), .comm_rx_full(comm_rx_full), .comm_tx_full(comm_tx_full)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    reg_en = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    tick();
    reg_en = 0;
  endtask

  task automatic prog(input int u, input logic [31:0] av, am, dv, dm,
                      input logic [8:0] cv, input logic [7:0] cm);
    logic [4:0] b;
    b = (u == 0) ? 5'h08 : 5'h10;
    wreg(b | 5'd0, av); wreg(b | 5'd1, am); wreg(b | 5'd2, dv); wreg(b | 5'd3, dm);
    wreg(b | 5'd4, {23'b0, cv}); wreg(b | 5'd5, {24'b0, cm});
  endtask

  task automatic acc(input logic f, input logic w, input logic [31:0] a, input logic [31:0] d);
    bus_fetch = f; bus_write = w; bus_addr = a; bus_data = d; bus_valid = 1;
    tick();
    bus_valid = 0; bus_fetch = 0; bus_write = 0;
  endtask

  task automatic drain();
    instr_done = 1; tick(); instr_done = 0;
    dbg_resume = 1; tick(); dbg_resume = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R1 reset state
    for (int a = 0; a < 32; a++) begin
      rreg(5'(a), rv);
      chk("R1 reg", rv, 0);
    end
    chk("R1 ack", {31'b0, dbg_ack}, 0);
    chk("R1 rng", {30'b0, rng}, 0);
    chk("R1 flags", {29'b0, intr_block, comm_rx_full, comm_tx_full}, 0);
    chk("R1 core_rdata", core_rdata, 0);

    // R2 mask sweep on the low address nibble
    prog(0, 32'h1234_5675, 32'h0, 32'h0, 32'hFFFF_FFFF, EN, 8'hFF);
    for (int m = 0; m < 16; m++) begin
      wreg(5'h09, {28'h0, 4'(m)});
      for (int a = 0; a < 16; a++) begin
        acc(0, 0, {28'h1234567, 4'(a)}, 32'h0);
        chk("R2 sweep", {31'b0, rng[0]}, {31'b0, (((a ^ 5) & ~m & 15) == 0)});
      end
    end
    acc(0, 0, 32'h0234_5675, 32'h0);
    chk("R2 upper bit", {31'b0, rng[0]}, 0);
    wreg(5'h0A, 32'hCAFE_F00D); wreg(5'h0B, 32'h0);
    acc(0, 0, 32'h1234_5670, 32'hCAFE_F00D);
    chk("R2 data eq", {31'b0, rng[0]}, 1);
    acc(0, 0, 32'h1234_5670, 32'hCAFE_F00C);
    chk("R2 data ne", {31'b0, rng[0]}, 0);

    // R3 enable and control fields
    wreg(5'h0C, 32'h0); wreg(5'h0D, 32'hFF);
    acc(0, 0, 32'h1234_5670, 32'hCAFE_F00D);
    chk("R3 disabled", {31'b0, rng[0]}, 0);
    wreg(5'h0C, {23'b0, EN | 9'h001}); wreg(5'h0D, 32'hFE);
    acc(0, 1, 32'h1234_5670, 32'hCAFE_F00D);
    chk("R3 write bit", {31'b0, rng[0]}, 1);
    acc(0, 0, 32'h1234_5670, 32'hCAFE_F00D);
    chk("R3 read no match", {31'b0, rng[0]}, 0);
    wreg(5'h0C, {23'b0, EN | 9'h020}); wreg(5'h0D, 32'hDF);
    ext_in = 2'b00;
    acc(0, 0, 32'h1234_5670, 32'hCAFE_F00D);
    chk("R3 ext low", {31'b0, rng[0]}, 0);
    ext_in = 2'b01;
    acc(0, 0, 32'h1234_5670, 32'hCAFE_F00D);
    chk("R3 ext high", {31'b0, rng[0]}, 1);
    ext_in = 2'b00;
    drain();

    // R4 range window 32..255
    prog(0, 32'h0, 32'h1F, 32'h0, 32'hFFFF_FFFF, EN, 8'hFF);
    prog(1, 32'h0, 32'hFF, 32'h0, 32'hFFFF_FFFF, EN, 8'h7F);
    for (int k = 0; k < 64; k++) begin
      acc(0, 0, 32'(k * 8), 32'h0);
      chk("R4 unit1", {31'b0, rng[1]}, {31'b0, (k * 8 >= 32 && k * 8 < 256)});
      chk("R4 unit0", {31'b0, rng[0]}, {31'b0, (k * 8 < 32)});
    end
    drain();

    // R5 chain
    prog(1, 32'h200, 32'h0, 32'h0, 32'hFFFF_FFFF, EN | 9'h040, 8'hBF);
    prog(0, 32'h100, 32'h0, 32'h0, 32'hFFFF_FFFF, EN, 8'hFF);
    rreg(5'h01, rv); chk("R5 latch clear", {31'b0, rv[3]}, 0);
    acc(0, 0, 32'h200, 0); chk("R5 before first", {31'b0, rng[1]}, 0);
    acc(0, 0, 32'h100, 0); chk("R5 first", {31'b0, rng[0]}, 1);
    rreg(5'h01, rv); chk("R5 latch set", {31'b0, rv[3]}, 1);
    acc(0, 0, 32'h200, 0); chk("R5 second", {31'b0, rng[1]}, 1);
    acc(0, 0, 32'h200, 0); chk("R5 second again", {31'b0, rng[1]}, 1);
    wreg(5'h09, 32'h0);
    rreg(5'h01, rv); chk("R5 write clears", {31'b0, rv[3]}, 0);
    acc(0, 0, 32'h200, 0); chk("R5 after clear", {31'b0, rng[1]}, 0);
    drain();

    // R6 breakpoint reaching execute
    wreg(5'h14, 32'h0);
    prog(0, 32'h400, 32'h0, 32'h0, 32'hFFFF_FFFF, EN | 9'h010, 8'hEF);
    acc(1, 0, 32'h400, 0);
    chk("R6 tag hit", {31'b0, rng[0]}, 1);
    chk("R6 no halt yet", {31'b0, dbg_ack}, 0);
    acc(1, 0, 32'h404, 0); chk("R6 decode", {31'b0, dbg_ack}, 0);
    acc(1, 0, 32'h408, 0); chk("R6 execute", {31'b0, dbg_ack}, 1);
    rreg(5'h01, rv); chk("R6 cause", {31'b0, rv[4]}, 1);
    dbg_resume = 1; tick(); dbg_resume = 0;
    chk("R6 resumed", {31'b0, dbg_ack}, 0);
    acc(1, 0, 32'h400, 0);
    flush = 1; tick(); flush = 0;
    acc(1, 0, 32'h404, 0); acc(1, 0, 32'h408, 0);
    chk("R6 flushed", {31'b0, dbg_ack}, 0);
    acc(0, 0, 32'h400, 0); chk("R6 data not fetch", {31'b0, rng[0]}, 0);
    drain();

    // R7 watchpoint
    wreg(5'h0C, 32'h0);
    prog(1, 32'h800, 32'h0, 32'h0, 32'hFFFF_FFFF, EN | 9'h001, 8'hEE);
    acc(0, 1, 32'h800, 32'h1);
    chk("R7 match", {31'b0, rng[1]}, 1);
    rreg(5'h01, rv); chk("R7 pending", {31'b0, rv[2]}, 1);
    chk("R7 waits", {31'b0, dbg_ack}, 0);
    instr_done = 1; tick(); instr_done = 0;
    chk("R7 enter", {31'b0, dbg_ack}, 1);
    rreg(5'h01, rv); chk("R7 pending cleared", {31'b0, rv[2]}, 0);
    chk("R7 cause not bp", {31'b0, rv[4]}, 0);
    dbg_resume = 1; tick(); dbg_resume = 0;
    acc(0, 0, 32'h800, 32'h1); chk("R7 read ignored", {31'b0, rng[1]}, 0);
    wreg(5'h14, 32'h0);
    drain();

    // R8 request and force
    dbg_req = 1; tick(); tick();
    chk("R8 waits boundary", {31'b0, dbg_ack}, 0);
    rreg(5'h01, rv); chk("R12 status req", {27'b0, rv[4:0]}, 32'h02);
    instr_done = 1; tick(); instr_done = 0;
    chk("R8 enter", {31'b0, dbg_ack}, 1);
    dbg_req = 0; tick(); tick();
    chk("R8 holds", {31'b0, dbg_ack}, 1);
    dbg_resume = 1; tick(); dbg_resume = 0; tick();
    chk("R8 resume", {31'b0, dbg_ack}, 0);
    wreg(5'h00, 32'h1);
    instr_done = 1; tick(); instr_done = 0;
    chk("R8 force", {31'b0, dbg_ack}, 1);
    wreg(5'h00, 32'h0);
    dbg_resume = 1; tick(); dbg_resume = 0;
    chk("R8 force resume", {31'b0, dbg_ack}, 0);

    // R12 interrupt disable control
    wreg(5'h00, 32'h2); chk("R12 intr on", {31'b0, intr_block}, 1);
    wreg(5'h00, 32'h0); chk("R12 intr off", {31'b0, intr_block}, 0);

    // R9 register map readback
    for (int u = 0; u < 2; u++) begin
      for (int s = 0; s < 6; s++) begin
        logic [4:0] a;
        logic [31:0] pat, exp;
        a = 5'((u + 1) * 8 + s);
        pat = 32'hA5C3_96E1 ^ (32'(a) * 32'h0101_0101);
        exp = (s == 4) ? (pat & 32'h1FF) : (s == 5) ? (pat & 32'hFF) : pat;
        wreg(a, pat);
        rreg(a, rv);
        chk("R9 unit reg", rv, exp);
      end
    end
    wreg(5'h00, 32'hFFFF_FFFC); rreg(5'h00, rv); chk("R9 dctl width", rv, 32'h3C);
    wreg(5'h00, 32'h0);
    rreg(5'h02, rv); chk("R9 unmapped 02", rv, 0);
    rreg(5'h0E, rv); chk("R9 unmapped 0E", rv, 0);
    rreg(5'h1F, rv); chk("R9 unmapped 1F", rv, 0);

    // R10 host to core
    wreg(5'h05, 32'h1111_2222);
    chk("R10 full", {31'b0, comm_rx_full}, 1);
    chk("R10 data", core_rdata, 32'h1111_2222);
    rreg(5'h04, rv); chk("R10 flag bit0", rv, 32'h1);
    wreg(5'h05, 32'h3333_4444);
    chk("R10 write ignored", core_rdata, 32'h1111_2222);
    core_rd = 1; tick(); core_rd = 0;
    chk("R10 cleared", {31'b0, comm_rx_full}, 0);
    wreg(5'h05, 32'h3333_4444);
    chk("R10 new data", core_rdata, 32'h3333_4444);
    core_rd = 1; tick(); core_rd = 0;

    // R11 core to host
    core_wr = 1; core_wdata = 32'hDEAD_0001; tick(); core_wr = 0;
    chk("R11 full", {31'b0, comm_tx_full}, 1);
    rreg(5'h04, rv); chk("R11 flag bit1", rv, 32'h2);
    core_wr = 1; core_wdata = 32'hDEAD_0002; tick(); core_wr = 0;
    rreg(5'h05, rv); chk("R11 first word", rv, 32'hDEAD_0001);
    chk("R11 cleared", {31'b0, comm_tx_full}, 0);
    core_wr = 1; core_wdata = 32'hDEAD_0003; tick(); core_wr = 0;
    rreg(5'h05, rv); chk("R11 next word", rv, 32'hDEAD_0003);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule